// File: doc/BRIEF.md
# Transactional Line Cache

This block is a small, fully associative cache that sits beside a processor's regular data cache and holds everything one hardware transaction touches. Transactional loads add lines to the transaction's read set. Transactional stores and load-exclusive accesses add lines to its write set. Stored data is tentative: the local processor can read it back, but it never appears on the writeback port while the transaction is open. A line is held either here or in the regular cache, never in both. The regular cache and the bus protocol sit outside this block.

Other processors' bus traffic arrives on a snoop input. A remote write to a read-set line, or a remote read or write to a write-set line, marks the transaction as failed. A transaction that needs a fresh line when every line already belongs to it is also marked failed. Three commands end or inspect the transaction, and each finishes in one cycle with a bulk update of the per-line state bits. Commit publishes the tentative lines as ordinary dirty lines, or discards them if the transaction has failed. Abort always discards them. Validate reports the status and discards the write set only when the transaction has failed.

Memory data enters through a fill port. Dirty data leaves through a writeback port. Every output is registered and appears in the cycle after the request that caused it.

Top module: `txn_line_cache`

## Requirements
- R1: After reset every line is invalid, the transaction is not failed, and `resp_valid`, `cmd_done` and `wb_valid` are low. A load after reset reports a miss, and a validate after reset reports success.
- R2: A request uses `req_op` = 0 for a load, 1 for a load-exclusive and 2 for a store (3 acts as a load). A load that hits returns the line's data one cycle later with `resp_miss`=0 and adds the line to the read set. A load that misses reports `resp_miss`=1. A fill of an absent address, presented in a cycle with no request and no command, installs the line as clean and not part of any set.
- R3: A store writes the whole line tentatively and adds it to the write set. A later local load returns the new value, and `wb_valid` stays low. If the store or load-exclusive claims a dirty line that is not yet in the write set, the old line is first emitted on the writeback port in the response cycle.
- R4: Any of the following marks the transaction failed, and the failure persists until a command ends the transaction: a snooped write (`snoop_write`=1) to a read-set line, or a snooped read or write to a write-set line. A snooped read of a line that is only in the read set causes no failure.
- R5: A command uses `cmd_op` = 0 for commit, 1 for abort and 2 for validate (3 acts as validate). `cmd_done` rises one cycle after the command. A commit of a transaction that has not failed returns `cmd_ok`=1 and turns the write-set lines into valid dirty lines. Commit and abort clear both sets.
- R6: A failed commit (`cmd_ok`=0) and an abort (which always reports `cmd_ok`=0) both invalidate every write-set line, so a later load of such a line misses.
- R7: A validate returns `cmd_ok`=1 when the transaction has not failed, and then leaves both sets unchanged. When the transaction has failed, validate returns 0, discards the write set and ends the transaction.
- R8: A load-exclusive returns the line data unchanged but places the line in the write set. A remote read of that line therefore fails the transaction, and a later commit discards the line.
- R9: A miss that needs a line when every valid line is in the read or write set fails the transaction and evicts nothing. A store that fails this way reports `resp_miss`=1.
- R10: A conflicting snoop in the same cycle as a commit makes that commit fail.
- R11: A command takes priority over a request in the same cycle. The request is ignored, and no `resp_valid` follows it.
- R12: An allocation takes the lowest-numbered invalid line. If there is none, it takes the lowest-numbered line that is in neither set. A dirty victim is written out on `wb_addr`/`wb_data` with `wb_valid`=1 in the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request strobe |
| req_op | input | 2 | 0 load, 1 load-exclusive, 2 store |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | DATA_W | Store data (whole line) |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_miss | output | 1 | Load missed, or store found no room |
| resp_rdata | output | DATA_W | Load data |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 commit, 1 abort, 2 validate |
| cmd_done | output | 1 | Command finished |
| cmd_ok | output | 1 | Command result |
| snoop_valid | input | 1 | Remote access observed |
| snoop_write | input | 1 | Remote access is a write |
| snoop_addr | input | ADDR_W | Remote line address |
| fill_valid | input | 1 | Fill strobe from memory |
| fill_addr | input | ADDR_W | Fill line address |
| fill_data | input | DATA_W | Fill line data |
| wb_valid | output | 1 | Writeback strobe |
| wb_addr | output | ADDR_W | Writeback line address |
| wb_data | output | DATA_W | Writeback line data |

## Verification
The bound checker watches, on every cycle, the invariants that hold regardless of the data:
- no address matches two lines;
- the write set only contains valid lines;
- the failure flag stays set until a command arrives;
- a response follows exactly the requests that no command overrode;
- commit and abort leave both sets empty;
- a commit issued while the flag is set reports failure.

Only the directed scenarios can show that data values are right. These include tentative data read back locally, committed data leaving through the writeback port with the correct address, the claim writeback of an older dirty copy, and the choice of victim. The scenarios also show that the conflict rules tell read-only lines from exclusive lines, and how the block behaves once all 64 lines belong to the transaction.

// File: rtl/txc_pkg.sv
// Shared encodings for the transactional line cache.
// Assumes two-bit opcode fields on both the request and command ports.
package txc_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_LOADX = 2'd1,
        OP_STORE = 2'd2,
        OP_ALT   = 2'd3
    } req_op_e;

    typedef enum logic [1:0] {
        CMD_COMMIT   = 2'd0,
        CMD_ABORT    = 2'd1,
        CMD_VALIDATE = 2'd2,
        CMD_ALT      = 2'd3
    } cmd_op_e;
endpackage

// File: rtl/txc_tag_match.sv
// Parallel tag comparator: one comparator per line.
// Assumes only valid lines may match and that tags are unique among valid lines.
module txc_tag_match #(
    parameter int LINES  = 64,
    parameter int ADDR_W = 29
) (
    input  logic [LINES-1:0]  line_valid,
    input  logic [ADDR_W-1:0] line_tag [LINES],
    input  logic [ADDR_W-1:0] probe,
    output logic [LINES-1:0]  hit
);
    // One equality compare per line, gated by the valid bit.
    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign hit[g] = line_valid[g] && (line_tag[g] == probe);
    end
endmodule

// File: rtl/txc_victim_pick.sv
// Picks the line to allocate: the lowest-numbered invalid line, or, when none
// is free, the lowest-numbered valid line outside both transaction sets.
// Assumes the set-membership bits are only ever set on valid lines.
module txc_victim_pick #(
    parameter int LINES = 64,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] line_v,
    input  logic [LINES-1:0] line_r,
    input  logic [LINES-1:0] line_w,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    logic [LINES-1:0] free_vec;
    logic [LINES-1:0] spare_vec;
    logic [LINES-1:0] pick_vec;

    // Candidate vector: free lines first, otherwise lines outside both sets.
    always_comb begin
        free_vec  = ~line_v;
        spare_vec = line_v & ~line_r & ~line_w;
        pick_vec  = (|free_vec) ? free_vec : spare_vec;
    end

    // Priority encoder: the lowest set bit of the candidate vector wins.
    always_comb begin
        found = |pick_vec;
        idx   = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pick_vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/txn_line_cache.sv
// Fully associative transactional line cache holding one transaction's
// read set and tentative write set. Snooped remote accesses that conflict
// set a sticky failure flag. Commit, abort and validate update all lines in a
// single cycle. Assumes whole-line stores and at most one of request,
// command or fill acting per cycle (command first, then request, then fill).
module txn_line_cache
    import txc_pkg::*;
#(
    parameter int LINES  = 64,
    parameter int ADDR_W = 29,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic              resp_miss,
    output logic [DATA_W-1:0] resp_rdata,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    output logic              cmd_done,
    output logic              cmd_ok,
    input  logic              snoop_valid,
    input  logic              snoop_write,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);
    localparam int IDX_W = $clog2(LINES);

    logic [LINES-1:0]  v_q, d_q, r_q, w_q;
    logic              failed_q;
    logic [ADDR_W-1:0] tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    logic [LINES-1:0]  req_hit, snp_hit, fill_hit;
    logic              vic_found;
    logic [IDX_W-1:0]  vic_idx, hit_idx;
    logic              hit_any, do_req, is_claim, is_store;
    logic              snp_conflict, fail_now, miss_noroom;
    logic              store_alloc, do_fill, claim_wb, evict_wb;
    req_op_e           op;
    cmd_op_e           cop;

    txc_tag_match #(.LINES(LINES), .ADDR_W(ADDR_W)) u_req_match (
        .line_valid(v_q), .line_tag(tag_q), .probe(req_addr), .hit(req_hit)
    );
    txc_tag_match #(.LINES(LINES), .ADDR_W(ADDR_W)) u_snp_match (
        .line_valid(v_q), .line_tag(tag_q), .probe(snoop_addr), .hit(snp_hit)
    );
    txc_tag_match #(.LINES(LINES), .ADDR_W(ADDR_W)) u_fill_match (
        .line_valid(v_q), .line_tag(tag_q), .probe(fill_addr), .hit(fill_hit)
    );
    txc_victim_pick #(.LINES(LINES), .IDX_W(IDX_W)) u_victim (
        .line_v(v_q), .line_r(r_q), .line_w(w_q), .found(vic_found), .idx(vic_idx)
    );

    // Encode the (single) request hit into a line index.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (req_hit[i]) hit_idx = IDX_W'(i);
        end
    end

    // Decode the request, conflicts and allocation decisions for this cycle.
    always_comb begin
        op           = req_op_e'(req_op);
        cop          = cmd_op_e'(cmd_op);
        hit_any      = |req_hit;
        do_req       = req_valid && !cmd_valid;
        is_store     = (op == OP_STORE);
        is_claim     = (op == OP_STORE) || (op == OP_LOADX);
        snp_conflict = snoop_valid &&
                       (|(snp_hit & (w_q | (r_q & {LINES{snoop_write}}))));
        fail_now     = failed_q || snp_conflict;
        miss_noroom  = do_req && !hit_any && !vic_found;
        store_alloc  = do_req && !hit_any && is_store && vic_found;
        do_fill      = fill_valid && !req_valid && !cmd_valid &&
                       !(|fill_hit) && vic_found;
        claim_wb     = do_req && hit_any && is_claim && d_q[hit_idx] && !w_q[hit_idx];
        evict_wb     = (store_alloc || do_fill) && v_q[vic_idx] && d_q[vic_idx];
    end

    // Line state bits, failure flag and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q        <= '0;
            d_q        <= '0;
            r_q        <= '0;
            w_q        <= '0;
            failed_q   <= 1'b0;
            resp_valid <= 1'b0;
            resp_miss  <= 1'b0;
            resp_rdata <= '0;
            cmd_done   <= 1'b0;
            cmd_ok     <= 1'b0;
            wb_valid   <= 1'b0;
            wb_addr    <= '0;
            wb_data    <= '0;
        end else begin
            resp_valid <= 1'b0;
            cmd_done   <= 1'b0;
            wb_valid   <= claim_wb || evict_wb;
            if (claim_wb) begin
                wb_addr <= tag_q[hit_idx];
                wb_data <= data_q[hit_idx];
            end else if (evict_wb) begin
                wb_addr <= tag_q[vic_idx];
                wb_data <= data_q[vic_idx];
            end
            if (cmd_valid) begin
                cmd_done <= 1'b1;
                r_q      <= '0;
                w_q      <= '0;
                failed_q <= 1'b0;
                case (cop)
                    CMD_COMMIT: begin
                        cmd_ok <= !fail_now;
                        if (fail_now) v_q <= v_q & ~w_q;
                        else          d_q <= d_q | w_q;
                    end
                    CMD_ABORT: begin
                        cmd_ok <= 1'b0;
                        v_q    <= v_q & ~w_q;
                    end
                    default: begin
                        cmd_ok <= !fail_now;
                        if (fail_now) begin
                            v_q <= v_q & ~w_q;
                        end else begin
                            r_q <= r_q;
                            w_q <= w_q;
                        end
                    end
                endcase
            end else begin
                failed_q <= failed_q || snp_conflict || miss_noroom;
                if (do_req) begin
                    resp_valid <= 1'b1;
                    resp_miss  <= !hit_any && !store_alloc;
                    resp_rdata <= (hit_any && !is_store) ? data_q[hit_idx] : '0;
                    if (hit_any) begin
                        if (!is_store) r_q[hit_idx] <= 1'b1;
                        if (is_claim)  w_q[hit_idx] <= 1'b1;
                        if (claim_wb)  d_q[hit_idx] <= 1'b0;
                    end else if (store_alloc) begin
                        v_q[vic_idx] <= 1'b1;
                        d_q[vic_idx] <= 1'b0;
                        r_q[vic_idx] <= 1'b0;
                        w_q[vic_idx] <= 1'b1;
                    end
                end else if (do_fill) begin
                    v_q[vic_idx] <= 1'b1;
                    d_q[vic_idx] <= 1'b0;
                    r_q[vic_idx] <= 1'b0;
                    w_q[vic_idx] <= 1'b0;
                end
            end
        end
    end

    // Tag and data storage writes for stores, allocations and fills.
    always_ff @(posedge clk) begin
        if (do_req && hit_any && is_store) begin
            data_q[hit_idx] <= req_wdata;
        end else if (store_alloc) begin
            tag_q[vic_idx]  <= req_addr;
            data_q[vic_idx] <= req_wdata;
        end else if (do_fill) begin
            tag_q[vic_idx]  <= fill_addr;
            data_q[vic_idx] <= fill_data;
        end
    end
endmodule

// File: rtl/txc_checker.sv
// Protocol and invariant checks for txn_line_cache, bound into every instance.
// Assumes the opcode encodings of txc_pkg.
module txc_checker #(
    parameter int LINES = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic             cmd_done,
    input logic             cmd_ok,
    input logic             resp_valid,
    input logic             failed_q,
    input logic [LINES-1:0] v_q,
    input logic [LINES-1:0] r_q,
    input logic [LINES-1:0] w_q,
    input logic [LINES-1:0] req_hit
);
    // R2: an address never matches more than one line.
    p_unique_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_hit));

    // R3: write-set membership only on valid lines.
    p_wset_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q & ~v_q) == '0);

    // R4: the failure flag is sticky until a command.
    p_fail_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (failed_q && !cmd_valid) |=> failed_q);

    // R5: commit and abort end the transaction with empty sets.
    p_sets_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 2'd0 || cmd_op == 2'd1))
        |=> (r_q == '0 && w_q == '0 && !failed_q));

    // R6: a commit while failed reports failure.
    p_commit_fails_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd0 && failed_q) |=> (cmd_done && !cmd_ok));

    // R11: a request alone gets a response.
    p_resp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cmd_valid) |=> resp_valid);

    // R11: a command suppresses the same-cycle response and completes.
    p_cmd_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (cmd_done && !resp_valid));
endmodule

bind txn_line_cache txc_checker #(.LINES(LINES)) u_txc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_done   (cmd_done),
    .cmd_ok     (cmd_ok),
    .resp_valid (resp_valid),
    .failed_q   (failed_q),
    .v_q        (v_q),
    .r_q        (r_q),
    .w_q        (w_q),
    .req_hit    (req_hit)
);

// File: tb/tb_txn_line_cache.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_txn_line_cache;
    localparam int LINES  = 64;
    localparam int ADDR_W = 29;
    localparam int DATA_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              resp_valid, resp_miss;
    logic [DATA_W-1:0] resp_rdata;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'd0;
    logic              cmd_done, cmd_ok;
    logic              snoop_valid = 1'b0;
    logic              snoop_write = 1'b0;
    logic [ADDR_W-1:0] snoop_addr = '0;
    logic              fill_valid = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [DATA_W-1:0] fill_data = '0;
    logic              wb_valid;
    logic [ADDR_W-1:0] wb_addr;
    logic [DATA_W-1:0] wb_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    txn_line_cache #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_miss(resp_miss), .resp_rdata(resp_rdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_done(cmd_done), .cmd_ok(cmd_ok),
        .snoop_valid(snoop_valid), .snoop_write(snoop_write), .snoop_addr(snoop_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Each driver applies inputs at a falling edge and returns at the next
    // falling edge, when the registered results of that rising edge are stable.
    task automatic do_req(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_cmd(input logic [1:0] c);
        cmd_valid = 1'b1; cmd_op = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_snoop(input logic wr, input logic [ADDR_W-1:0] a);
        snoop_valid = 1'b1; snoop_write = wr; snoop_addr = a;
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    task automatic do_fill(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        fill_valid = 1'b1; fill_addr = a; fill_data = d;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 resp_valid", 64'(resp_valid), 64'd0);
        check("R1 cmd_done", 64'(cmd_done), 64'd0);
        check("R1 wb_valid", 64'(wb_valid), 64'd0);
        do_req(2'd0, 29'h100, '0);
        check("R1 load miss", 64'(resp_miss), 64'd1);
        do_cmd(2'd2);
        check("R1 validate ok", 64'(cmd_ok), 64'd1);
    endtask

    task automatic t_load_fill;
        do_req(2'd0, 29'h200, '0);
        check("R2 miss", 64'(resp_miss), 64'd1);
        do_fill(29'h200, 64'hAAAA_0000_1111_2222);
        do_req(2'd0, 29'h200, '0);
        check("R2 hit", 64'(resp_miss), 64'd0);
        check("R2 data", resp_rdata, 64'hAAAA_0000_1111_2222);
        do_cmd(2'd1);
    endtask

    task automatic t_store_local;
        do_req(2'd2, 29'h200, 64'hBEEF);
        check("R3 store no wb", 64'(wb_valid), 64'd0);
        do_req(2'd0, 29'h200, '0);
        check("R3 local read", resp_rdata, 64'hBEEF);
        check("R3 no wb on read", 64'(wb_valid), 64'd0);
        do_cmd(2'd1);
        check("R6 abort reports 0", 64'(cmd_ok), 64'd0);
        do_req(2'd0, 29'h200, '0);
        check("R6 abort discards", 64'(resp_miss), 64'd1);
    endtask

    task automatic t_commit;
        do_req(2'd2, 29'h300, 64'hF00D);
        check("R5 store alloc", 64'(resp_miss), 64'd0);
        do_cmd(2'd0);
        check("R5 commit ok", 64'(cmd_ok), 64'd1);
        do_req(2'd2, 29'h300, 64'h1234);
        check("R3 claim wb valid", 64'(wb_valid), 64'd1);
        check("R3 claim wb addr", 64'(wb_addr), 64'h300);
        check("R5 committed data", wb_data, 64'hF00D);
        do_cmd(2'd1);
        do_req(2'd0, 29'h300, '0);
        check("R6 abort after claim", 64'(resp_miss), 64'd1);
    endtask

    task automatic t_snoop;
        do_fill(29'h400, 64'h44);
        do_req(2'd0, 29'h400, '0);
        do_snoop(1'b0, 29'h400);
        do_cmd(2'd2);
        check("R4 remote read of read set", 64'(cmd_ok), 64'd1);
        do_snoop(1'b1, 29'h400);
        do_cmd(2'd2);
        check("R7 validate reports fail", 64'(cmd_ok), 64'd0);
        do_cmd(2'd0);
        check("R7 fresh txn commit", 64'(cmd_ok), 64'd1);
        do_req(2'd1, 29'h400, '0);
        check("R8 loadx data", resp_rdata, 64'h44);
        do_snoop(1'b0, 29'h400);
        do_cmd(2'd0);
        check("R8 remote read fails", 64'(cmd_ok), 64'd0);
        do_req(2'd0, 29'h400, '0);
        check("R8 line discarded", 64'(resp_miss), 64'd1);
    endtask

    task automatic t_same_cycle;
        do_req(2'd2, 29'h500, 64'h55);
        cmd_valid = 1'b1; cmd_op = 2'd0;
        snoop_valid = 1'b1; snoop_write = 1'b0; snoop_addr = 29'h500;
        @(negedge clk);
        cmd_valid = 1'b0; snoop_valid = 1'b0;
        check("R10 commit with snoop", 64'(cmd_ok), 64'd0);
    endtask

    task automatic t_precedence;
        req_valid = 1'b1; req_op = 2'd2; req_addr = 29'h600; req_wdata = 64'h66;
        cmd_valid = 1'b1; cmd_op = 2'd1;
        @(negedge clk);
        req_valid = 1'b0; cmd_valid = 1'b0;
        check("R11 no resp", 64'(resp_valid), 64'd0);
        check("R11 cmd done", 64'(cmd_done), 64'd1);
        do_req(2'd0, 29'h600, '0);
        check("R11 store ignored", 64'(resp_miss), 64'd1);
    endtask

    task automatic t_capacity;
        int bad = 0;
        for (int i = 0; i < LINES; i++) begin
            do_req(2'd2, ADDR_W'(32'h1000 + i), 64'(i));
            if (resp_miss !== 1'b0) bad++;
        end
        check("R9 all lines taken", 64'(bad), 64'd0);
        do_req(2'd2, 29'h2000, 64'h99);
        check("R9 no room", 64'(resp_miss), 64'd1);
        check("R9 no eviction wb", 64'(wb_valid), 64'd0);
        do_cmd(2'd0);
        check("R9 commit fails", 64'(cmd_ok), 64'd0);
    endtask

    task automatic t_evict;
        do_req(2'd2, 29'h3000, 64'hCAFE);
        do_cmd(2'd0);
        check("R5 commit ok", 64'(cmd_ok), 64'd1);
        for (int i = 1; i < LINES; i++) do_fill(ADDR_W'(32'h4000 + i), 64'(i));
        do_req(2'd2, 29'h5000, 64'h77);
        check("R12 alloc ok", 64'(resp_miss), 64'd0);
        check("R12 dirty victim wb", 64'(wb_valid), 64'd1);
        check("R12 victim addr", 64'(wb_addr), 64'h3000);
        check("R12 victim data", wb_data, 64'hCAFE);
        do_cmd(2'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_fill();
        t_store_local();
        t_commit();
        t_snoop();
        t_same_cycle();
        t_precedence();
        t_capacity();
        t_evict();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule